// File: doc/BRIEF.md
# Microcode ALU Stage with Carry Latch

This block is the arithmetic and logic stage of a microcoded processor's datapath. On each microcycle, it combines the value on the internal bus with the current T register, as selected by a 4-bit function code. It produces a 16-bit result and a carry-out. The function code also carries two attributes. The first says whether the operation is logic or arithmetic. The second says whether a T load takes the ALU result or the raw bus.

Two strobes control the registers. When the L strobe is set, the result goes into the L register, and a separate carry latch is loaded. The latch takes a forced 0 after a logic operation and the real carry after an arithmetic one. If the running task is flagged as memory-related, the M register takes the same result. When the T strobe is set, T is loaded from the ALU or the bus, and the control-store address register takes the ALU result. All register updates occur on a single clock edge.

Top module: `ualu_stage`

## Requirements
- R1: The logic codes are 0 (bus), 1 (T), 2 (bus OR T), 3 (bus AND T), 4 (bus XOR T), 12 (bus AND T) and 13 (bus AND NOT T). Each yields the named result with a carry-out of 1.
- R2: Code 5 (bus+1), code 7 (bus+T) and code 10 (bus+T+1) yield the 16-bit sum. Their carry-out is bit 16 of the 17-bit sum.
- R3: Code 6 (bus-1), code 8 (bus-T) and code 9 (bus-T-1) yield the 16-bit difference. Each carry-out is the inverse of bit 16 of the underlying sum, which gives 1 exactly when a borrow occurs.
- R4: Code 11 adds the skip input to the bus, with a normal carry-out.
- R5: A T load takes the ALU result for codes 0, 2, 5, 6, 10, 11, 12, 14 and 15. It takes the bus for codes 1, 3, 4, 7, 8, 9 and 13.
- R6: An L load stores the ALU result in L. The carry latch takes 0 after a logic code and the carry-out after an arithmetic code.
- R7: M takes the ALU result only when the L strobe and the memory-task flag are both set. Otherwise M holds its value.
- R8: A T load also stores the ALU result in the control-store address register.
- R9: Codes 14 and 15 pass the bus through with a carry-out of 1 and behave as logic codes.
- R10: When a strobe is clear, the registers it governs keep their values.
- R11: A synchronous active-high reset clears L, T, M, the carry latch and the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_i | input | 16 | Bus operand |
| fn_i | input | 4 | ALU function code |
| skip_i | input | 1 | Skip bit added by code 11 |
| load_l_i | input | 1 | Load strobe for L, the carry latch and M |
| load_t_i | input | 1 | Load strobe for T and the address register |
| ram_task_i | input | 1 | Running task is memory-related (enables the M load) |
| alu_o | output | 16 | Combinational ALU result |
| carry_o | output | 1 | Combinational ALU carry-out |
| l_o | output | 16 | L register |
| lcarry_o | output | 1 | Latched carry |
| t_o | output | 16 | T register (also the ALU's second operand) |
| m_o | output | 16 | M register |
| cram_addr_o | output | 16 | Control-store address register |

## Verification
The assertions assume that the function code, the bus, the skip bit and the three strobes are known, 2-state values whenever the clock rises, and that they are held steady across the edge. The bench meets this by driving every input on the falling edge to fixed, known values. Reset is held high from time zero. Because the ALU reads T, the vectors first load T with chosen values, then run each function against them, so that the carry and borrow edges are crossed.

// File: rtl/ualu_pkg.sv
`timescale 1ns/1ps
package ualu_pkg;

    localparam int unsigned FN_W = 4;

    typedef enum logic [FN_W-1:0] {
        FN_PASS_B  = 4'd0,
        FN_PASS_T  = 4'd1,
        FN_OR      = 4'd2,
        FN_AND     = 4'd3,
        FN_XOR     = 4'd4,
        FN_INC     = 4'd5,
        FN_DEC     = 4'd6,
        FN_ADD     = 4'd7,
        FN_SUB     = 4'd8,
        FN_SUBM1   = 4'd9,
        FN_ADDP1   = 4'd10,
        FN_ADDSKIP = 4'd11,
        FN_AND_TA  = 4'd12,
        FN_ANDN    = 4'd13,
        FN_RSV14   = 4'd14,
        FN_RSV15   = 4'd15
    } ufn_e;

    typedef struct packed {
        logic is_logic;
        logic t_from_alu;
        logic inv_carry;
    } fn_attr_t;

    function automatic fn_attr_t fn_attr(ufn_e f);
        fn_attr_t a;
        a = '{is_logic: 1'b1, t_from_alu: 1'b1, inv_carry: 1'b0};
        unique case (f)
            FN_PASS_B, FN_OR, FN_AND_TA, FN_RSV14, FN_RSV15: ;
            FN_PASS_T, FN_AND, FN_XOR, FN_ANDN: a.t_from_alu = 1'b0;
            FN_INC, FN_ADDP1, FN_ADDSKIP: a.is_logic = 1'b0;
            FN_DEC: begin
                a.is_logic  = 1'b0;
                a.inv_carry = 1'b1;
            end
            FN_ADD: begin
                a.is_logic   = 1'b0;
                a.t_from_alu = 1'b0;
            end
            FN_SUB, FN_SUBM1: begin
                a.is_logic   = 1'b0;
                a.t_from_alu = 1'b0;
                a.inv_carry  = 1'b1;
            end
            default: ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/ualu_decode.sv
`timescale 1ns/1ps
module ualu_decode
    import ualu_pkg::*;
(
    input  logic [FN_W-1:0] fn_code,
    output ufn_e            fn,
    output fn_attr_t        attr
);
    always_comb begin
        fn   = ufn_e'(fn_code);
        attr = fn_attr(ufn_e'(fn_code));
    end
endmodule

// File: rtl/ualu_core.sv
`timescale 1ns/1ps
module ualu_core
    import ualu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] bus,
    input  logic [W-1:0] treg,
    input  ufn_e         fn,
    input  fn_attr_t     attr,
    input  logic         skip,
    output logic [W-1:0] result,
    output logic         carry
);
    localparam logic [W-1:0] ONES = {W{1'b1}};

    logic [W-1:0] opb;
    logic [W-1:0] lres;
    logic         cin;
    logic [W:0]   sum;

    always_comb begin
        opb  = '0;
        cin  = 1'b0;
        lres = bus;
        unique case (fn)
            FN_PASS_T:  lres = treg;
            FN_OR:      lres = bus | treg;
            FN_AND,
            FN_AND_TA:  lres = bus & treg;
            FN_XOR:     lres = bus ^ treg;
            FN_ANDN:    lres = bus & ~treg;
            FN_INC:     cin  = 1'b1;
            FN_DEC:     opb  = ONES;
            FN_ADD:     opb  = treg;
            FN_SUB: begin
                opb = ~treg;
                cin = 1'b1;
            end
            FN_SUBM1:   opb  = ~treg;
            FN_ADDP1: begin
                opb = treg;
                cin = 1'b1;
            end
            FN_ADDSKIP: cin  = skip;
            default: ;
        endcase
        sum = {1'b0, bus} + {1'b0, opb} + {{W{1'b0}}, cin};
        if (attr.is_logic) begin
            result = lres;
            carry  = 1'b1;
        end else begin
            result = sum[W-1:0];
            carry  = sum[W] ^ attr.inv_carry;
        end
    end
endmodule

// File: rtl/ualu_regs.sv
`timescale 1ns/1ps
module ualu_regs
    import ualu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bus,
    input  logic [W-1:0] result,
    input  logic         carry,
    input  fn_attr_t     attr,
    input  logic         load_l,
    input  logic         load_t,
    input  logic         ram_task,
    output logic [W-1:0] l_q,
    output logic         lc_q,
    output logic [W-1:0] t_q,
    output logic [W-1:0] m_q,
    output logic [W-1:0] cram_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            l_q    <= '0;
            lc_q   <= 1'b0;
            t_q    <= '0;
            m_q    <= '0;
            cram_q <= '0;
        end else begin
            if (load_l) begin
                l_q  <= result;
                lc_q <= attr.is_logic ? 1'b0 : carry;
                if (ram_task) m_q <= result;
            end
            if (load_t) begin
                t_q    <= attr.t_from_alu ? result : bus;
                cram_q <= result;
            end
        end
    end
endmodule

// File: rtl/ualu_stage.sv
`timescale 1ns/1ps
module ualu_stage
    import ualu_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [W-1:0]    bus_i,
    input  logic [FN_W-1:0] fn_i,
    input  logic            skip_i,
    input  logic            load_l_i,
    input  logic            load_t_i,
    input  logic            ram_task_i,
    output logic [W-1:0]    alu_o,
    output logic            carry_o,
    output logic [W-1:0]    l_o,
    output logic            lcarry_o,
    output logic [W-1:0]    t_o,
    output logic [W-1:0]    m_o,
    output logic [W-1:0]    cram_addr_o
);
    ufn_e     fn;
    fn_attr_t attr;
    logic [W-1:0] t_q;

    ualu_decode u_dec (
        .fn_code (fn_i),
        .fn      (fn),
        .attr    (attr)
    );

    ualu_core #(.W(W)) u_core (
        .bus    (bus_i),
        .treg   (t_q),
        .fn     (fn),
        .attr   (attr),
        .skip   (skip_i),
        .result (alu_o),
        .carry  (carry_o)
    );

    ualu_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus_i),
        .result   (alu_o),
        .carry    (carry_o),
        .attr     (attr),
        .load_l   (load_l_i),
        .load_t   (load_t_i),
        .ram_task (ram_task_i),
        .l_q      (l_o),
        .lc_q     (lcarry_o),
        .t_q      (t_q),
        .m_q      (m_o),
        .cram_q   (cram_addr_o)
    );

    assign t_o = t_q;
endmodule

// File: rtl/ualu_stage_chk.sv
`timescale 1ns/1ps
module ualu_stage_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] bus_i,
    input logic [3:0]   fn_i,
    input logic         load_l_i,
    input logic         load_t_i,
    input logic         ram_task_i,
    input logic [W-1:0] alu_o,
    input logic         carry_o,
    input logic [W-1:0] l_o,
    input logic         lcarry_o,
    input logic [W-1:0] t_o,
    input logic [W-1:0] m_o,
    input logic [W-1:0] cram_addr_o
);
    // R1 and R9: every logic or reserved code reports a carry of 1
    a_r1_logic_carry: assert property (@(posedge clk) disable iff (rst)
        (fn_i inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd12, 4'd13, 4'd14, 4'd15}) |-> carry_o);

    a_r9_reserved_pass: assert property (@(posedge clk) disable iff (rst)
        (fn_i inside {4'd14, 4'd15}) |-> (alu_o == bus_i));

    a_r5_t_from_bus: assert property (@(posedge clk) disable iff (rst)
        (load_t_i && (fn_i inside {4'd1, 4'd3, 4'd4, 4'd7, 4'd8, 4'd9, 4'd13}))
        |=> (t_o == $past(bus_i)));

    a_r6_l_gets_alu: assert property (@(posedge clk) disable iff (rst)
        load_l_i |=> (l_o == $past(alu_o)));

    a_r6_latch_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (load_l_i && !carry_o) |=> !lcarry_o);

    a_r7_m_load: assert property (@(posedge clk) disable iff (rst)
        (load_l_i && ram_task_i) |=> (m_o == $past(alu_o)));

    a_r7_m_hold: assert property (@(posedge clk) disable iff (rst)
        !(load_l_i && ram_task_i) |=> $stable(m_o));

    a_r8_cram_load: assert property (@(posedge clk) disable iff (rst)
        load_t_i |=> (cram_addr_o == $past(alu_o)));

    a_r10_l_hold: assert property (@(posedge clk) disable iff (rst)
        !load_l_i |=> ($stable(l_o) && $stable(lcarry_o)));

    a_r10_t_hold: assert property (@(posedge clk) disable iff (rst)
        !load_t_i |=> ($stable(t_o) && $stable(cram_addr_o)));
endmodule

bind ualu_stage ualu_stage_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_i       (bus_i),
    .fn_i        (fn_i),
    .load_l_i    (load_l_i),
    .load_t_i    (load_t_i),
    .ram_task_i  (ram_task_i),
    .alu_o       (alu_o),
    .carry_o     (carry_o),
    .l_o         (l_o),
    .lcarry_o    (lcarry_o),
    .t_o         (t_o),
    .m_o         (m_o),
    .cram_addr_o (cram_addr_o)
);

// File: tb/test_ualu_stage.sv
`timescale 1ns/1ps
module test_ualu_stage;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_i = '0;
    logic [3:0]  fn_i = '0;
    logic        skip_i = 1'b0, load_l_i = 1'b0, load_t_i = 1'b0, ram_task_i = 1'b0;
    logic [15:0] alu_o, l_o, t_o, m_o, cram_addr_o;
    logic        carry_o, lcarry_o;

    always #10 clk = ~clk;

    ualu_stage i_ualu_stage (
        .clk(clk), .rst(rst), .bus_i(bus_i), .fn_i(fn_i), .skip_i(skip_i),
        .load_l_i(load_l_i), .load_t_i(load_t_i), .ram_task_i(ram_task_i),
        .alu_o(alu_o), .carry_o(carry_o), .l_o(l_o), .lcarry_o(lcarry_o),
        .t_o(t_o), .m_o(m_o), .cram_addr_o(cram_addr_o)
    );

    typedef struct {
        logic [15:0] alu;
        logic        c;
        logic [15:0] l, t, m, cram;
        logic        lc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0, n_bad = 0;
    bit   finished = 0;

    // bench model state
    logic [15:0] md_l = '0, md_t = '0, md_m = '0, md_cram = '0;
    logic        md_lc = 1'b0;

    task automatic cmp(string tag, string what, logic [15:0] got, logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic apply(input logic [3:0] f, input logic [15:0] b, input logic sk,
                         input logic ll, input logic lt, input logic rt, input string tag);
        exp_t e;
        int   bi, ti, r;
        logic c, logic_op, tsel;
        @(negedge clk);
        fn_i = f; bus_i = b; skip_i = sk; load_l_i = ll; load_t_i = lt; ram_task_i = rt;
        bi = int'(b); ti = int'(md_t);
        c = 1'b1; logic_op = 1'b1;
        case (f)
            4'd0, 4'd14, 4'd15: r = bi;
            4'd1:  r = ti;
            4'd2:  r = bi | ti;
            4'd3, 4'd12: r = bi & ti;
            4'd4:  r = bi ^ ti;
            4'd13: r = bi & (~ti & 16'hFFFF);
            4'd5:  begin r = bi + 1;      c = (r > 65535); logic_op = 0; end
            4'd6:  begin r = bi - 1;      c = (bi == 0);   logic_op = 0; end
            4'd7:  begin r = bi + ti;     c = (r > 65535); logic_op = 0; end
            4'd8:  begin r = bi - ti;     c = (bi < ti);   logic_op = 0; end
            4'd9:  begin r = bi - ti - 1; c = (bi <= ti);  logic_op = 0; end
            4'd10: begin r = bi + ti + 1; c = (r > 65535); logic_op = 0; end
            default: begin r = bi + int'(sk); c = (r > 65535); logic_op = 0; end
        endcase
        tsel = (f inside {4'd0, 4'd2, 4'd5, 4'd6, 4'd10, 4'd11, 4'd12, 4'd14, 4'd15});
        e.alu = 16'(r & 32'hFFFF);
        e.c   = c;
        if (ll) begin
            md_l  = e.alu;
            md_lc = logic_op ? 1'b0 : c;
            if (rt) md_m = e.alu;
        end
        if (lt) begin
            md_t    = tsel ? e.alu : b;
            md_cram = e.alu;
        end
        e.l = md_l; e.lc = md_lc; e.t = md_t; e.m = md_m; e.cram = md_cram;
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        exp_t        e;
        logic [15:0] a;
        logic        c;
        forever begin
            @(negedge clk);
            #8;
            if (q.size() > 0) begin
                e = q.pop_front();
                a = alu_o; c = carry_o;
                @(posedge clk);
                #5;
                cmp(e.tag, "alu", a, e.alu);
                cmp(e.tag, "carry", {15'd0, c}, {15'd0, e.c});
                cmp(e.tag, "L", l_o, e.l);
                cmp(e.tag, "latched carry", {15'd0, lcarry_o}, {15'd0, e.lc});
                cmp(e.tag, "T", t_o, e.t);
                cmp(e.tag, "M", m_o, e.m);
                cmp(e.tag, "cram addr", cram_addr_o, e.cram);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        cmp("R11", "L after reset", l_o, 16'h0);
        cmp("R11", "T after reset", t_o, 16'h0);
        cmp("R11", "M after reset", m_o, 16'h0);
        cmp("R11", "cram after reset", cram_addr_o, 16'h0);
        cmp("R11", "latched carry after reset", {15'd0, lcarry_o}, 16'h0);
        @(negedge clk);
        rst = 1'b0;

        // load T with 0x1234 via pass-bus (R5 ALU source)
        apply(4'd0,  16'h1234, 0, 1, 1, 1, "R5 pass bus into T");
        apply(4'd1,  16'hFFFF, 0, 1, 0, 0, "R1 pass T");
        apply(4'd2,  16'h00F0, 0, 1, 0, 1, "R1 OR");
        apply(4'd3,  16'h0F0F, 0, 1, 0, 0, "R1 AND");
        apply(4'd4,  16'hFFFF, 0, 1, 0, 0, "R1 XOR");
        apply(4'd13, 16'hFFFF, 0, 1, 0, 0, "R1 AND-NOT");
        // arithmetic carry cases
        apply(4'd5,  16'hFFFF, 0, 1, 0, 0, "R2 inc wrap");
        apply(4'd5,  16'h0010, 0, 1, 0, 0, "R2 inc");
        apply(4'd7,  16'hEDCC, 0, 1, 0, 0, "R2 add carry");
        apply(4'd7,  16'h0001, 0, 1, 0, 0, "R2 add");
        apply(4'd10, 16'hEDCB, 0, 1, 0, 0, "R2 add plus one carry");
        apply(4'd6,  16'h0000, 0, 1, 0, 0, "R3 dec borrow");
        apply(4'd6,  16'h0005, 0, 1, 0, 0, "R3 dec");
        apply(4'd8,  16'h1234, 0, 1, 0, 0, "R3 sub equal");
        apply(4'd8,  16'h1000, 0, 1, 0, 0, "R3 sub borrow");
        apply(4'd9,  16'h1234, 0, 1, 0, 0, "R3 sub minus one equal");
        apply(4'd9,  16'h1235, 0, 1, 0, 0, "R3 sub minus one");
        apply(4'd11, 16'hFFFF, 1, 1, 0, 0, "R4 skip wrap");
        apply(4'd11, 16'h0042, 0, 1, 0, 0, "R4 skip zero");
        apply(4'd11, 16'h0042, 1, 1, 0, 1, "R4 skip one");
        // logic after carry: latch must fall to 0
        apply(4'd5,  16'hFFFF, 0, 1, 0, 0, "R6 arith latch");
        apply(4'd12, 16'hFFFF, 0, 1, 0, 0, "R6 logic clears latch");
        // T source selection
        apply(4'd5,  16'h0100, 0, 0, 1, 0, "R5 inc T from alu");
        apply(4'd7,  16'h0200, 0, 0, 1, 0, "R5 add T from bus");
        apply(4'd12, 16'hFF00, 0, 0, 1, 0, "R5 and-second T from alu");
        apply(4'd3,  16'h0F0F, 0, 0, 1, 0, "R5 and T from bus");
        apply(4'd11, 16'h7FFF, 1, 0, 1, 0, "R8 skip cram");
        apply(4'd8,  16'h9000, 0, 0, 1, 0, "R8 sub cram");
        // reserved codes
        apply(4'd5,  16'hFFFF, 0, 1, 0, 0, "R9 set latch");
        apply(4'd14, 16'hABCD, 0, 1, 1, 1, "R9 code 14");
        apply(4'd15, 16'h5A5A, 0, 1, 1, 0, "R9 code 15");
        // M gating and holds
        apply(4'd0,  16'h7777, 0, 1, 0, 0, "R7 M hold without task flag");
        apply(4'd0,  16'h8888, 0, 0, 0, 1, "R7 M hold without L strobe");
        apply(4'd6,  16'h0000, 0, 0, 0, 1, "R10 no strobes hold");
        apply(4'd4,  16'h3C3C, 0, 1, 0, 1, "R7 M load");
        repeat (4) @(posedge clk);
        #5;
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule